// File: doc/BRIEF.md
# Bus Idle-Time Guard

This block decides when a node on a shared single-wire control bus may begin a new message. After a start event it counts how long the bus has stayed high and raises `may_start` once the required idle time has passed. It counts in half-bit units, one step for each pulse of `half_tick`, which runs at twice the nominal bit rate. Any low level seen on the bus while the block is counting or ready clears the count, so the idle time always refers to one unbroken high stretch.

The idle time comes from a 3-bit code. A non-zero code `n` asks for `n - 0.5` bit periods. Code zero hands the choice to the bus history:

- a short wait after this node loses arbitration;
- the longest wait after this node finishes a message of its own;
- a middle wait for a new initiator, which covers the state after a reception and the state after reset.

A start-option input picks what starts the count. With the option clear, the count starts on a software request. With the option set, it starts on the end of any transmitted or received message.

Top module: `bus_idle_guard`

## Requirements
- R1: For a non-zero `idle_code` n, `may_start` needs 2n-1 counted half-bit ticks: 1 for code 1, 7 for code 4, 13 for code 7.
- R2: For `idle_code` 0, the target depends on the last recorded event. It is 5 ticks after `arb_lost`, 14 after `tx_done` and 10 after `rx_done` or reset. When pulses arrive in the same cycle, `arb_lost` wins over `tx_done`, and `tx_done` wins over `rx_done`.
- R3: With `start_on_end` = 0, only `sw_start` starts a count. `tx_done` and `rx_done` start nothing, but they still update the history.
- R4: With `start_on_end` = 1, `tx_done` or `rx_done` starts a count and `sw_start` has no effect.
- R5: While counting or ready, a cycle with `bus_hi` = 0 clears the count and drops `may_start`. The full target must then be counted again.
- R6: `may_start` rises at the clock edge that registers the target-th tick counted with `bus_hi` = 1. It then stays high until a start event, a low bus, or reset.
- R7: A start event always restarts the count from zero and drops `may_start`, even when the block is already ready. A tick in the same cycle as the start event is not counted.
- R8: Synchronous `rst` clears the count, deasserts `may_start`, stops counting and sets the history to new-initiator.
- R9: Before any start event, ticks with the bus high never raise `may_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| idle_code | input | 3 | Idle-time code; 0 selects the history-based default |
| start_on_end | input | 1 | 1: message ends start the count; 0: software request starts it |
| sw_start | input | 1 | Software start-of-message request, one-cycle pulse |
| tx_done | input | 1 | End of this node's successful transmission, pulse |
| rx_done | input | 1 | End of a received message, pulse |
| arb_lost | input | 1 | This node lost arbitration, pulse |
| half_tick | input | 1 | Half-bit-period tick |
| bus_hi | input | 1 | Sampled bus level, 1 = released/high |
| may_start | output | 1 | Idle time satisfied; a new message may begin |

## Verification
The bench builds the block with its default parameters: a 3-bit code and default targets of 5, 10 and 14 half-bits. With these values the 4-bit counter is exercised up to its largest target of 14, and every code from 1 to 7 can be reached within a few dozen cycles. Random stimulus switches the code and the start option at intervals. This brings in history changes during a count, start events that land on ticks, and bus drops just before the target is reached.

// File: rtl/idle_guard_pkg.sv
package idle_guard_pkg;

    typedef enum logic [1:0] {
        HIST_NEW  = 2'd0,
        HIST_LOST = 2'd1,
        HIST_OWN  = 2'd2
    } hist_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_COUNT = 2'd1,
        PH_READY = 2'd2
    } phase_e;

    // largest half-bit target reachable by any code or default
    function automatic int max_half(input int code_w, input int lost_h,
                                    input int new_h, input int own_h);
        int m;
        m = 2 * ((1 << code_w) - 1) - 1;
        if (lost_h > m) m = lost_h;
        if (new_h > m) m = new_h;
        if (own_h > m) m = own_h;
        return m;
    endfunction

endpackage

// File: rtl/ig_history.sv
module ig_history
    import idle_guard_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  arb_lost,
    input  logic  tx_done,
    input  logic  rx_done,
    output hist_e hist_o
);

    typedef struct packed {
        hist_e last;
    } hist_state_t;

    hist_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (arb_lost)      st_d.last = HIST_LOST;
        else if (tx_done)  st_d.last = HIST_OWN;
        else if (rx_done)  st_d.last = HIST_NEW;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{last: HIST_NEW};
        else     st_q <= st_d;
    end

    assign hist_o = st_q.last;

    // R2: arbitration loss takes priority over the other events
    a_r2_lost_wins: assert property (@(posedge clk) disable iff (rst)
        arb_lost |=> (hist_o == HIST_LOST));

    // R2: an own transmission without arbitration loss selects the long wait
    a_r2_own_tx: assert property (@(posedge clk) disable iff (rst)
        (tx_done && !arb_lost) |=> (hist_o == HIST_OWN));

    // R8: reset returns the history to new-initiator
    a_r8_hist_reset: assert property (@(posedge clk)
        rst |=> (hist_o == HIST_NEW));

    always_comb begin
        if (!rst) a_r2_legal_code: assert (st_q.last != hist_e'(2'd3));
    end

endmodule

// File: rtl/ig_target.sv
module ig_target
    import idle_guard_pkg::*;
#(
    parameter int CODE_W = 3,
    parameter int CNT_W  = 4,
    parameter int LOST_H = 5,
    parameter int NEW_H  = 10,
    parameter int OWN_H  = 14
) (
    input  logic [CODE_W-1:0] code,
    input  hist_e             hist,
    output logic [CNT_W-1:0]  target_o
);

    localparam int EXT_W = (CNT_W > CODE_W + 1) ? CNT_W : CODE_W + 1;

    logic [EXT_W-1:0] coded_h;

    // code n -> 2n-1 half-bit periods
    assign coded_h = {{(EXT_W-CODE_W-1){1'b0}}, code, 1'b0} - EXT_W'(1);

    always_comb begin
        if (code != '0) begin
            target_o = CNT_W'(coded_h);
        end else begin
            unique case (hist)
                HIST_LOST: target_o = CNT_W'(LOST_H);
                HIST_OWN:  target_o = CNT_W'(OWN_H);
                default:   target_o = CNT_W'(NEW_H);
            endcase
        end
    end

endmodule

// File: rtl/ig_window.sv
module ig_window
    import idle_guard_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trigger,
    input  logic             tick,
    input  logic             bus_hi,
    input  logic [CNT_W-1:0] target,
    output logic             may_start
);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
    } win_state_t;

    win_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (trigger) begin
            st_d.phase = PH_COUNT;
            st_d.cnt   = '0;
        end else if (st_q.phase != PH_IDLE && !bus_hi) begin
            st_d.phase = PH_COUNT;
            st_d.cnt   = '0;
        end else if (st_q.phase == PH_COUNT && tick) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_d.cnt >= target) st_d.phase = PH_READY;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{phase: PH_IDLE, cnt: '0};
        else     st_q <= st_d;
    end

    assign may_start = (st_q.phase == PH_READY);

    // R5: a low bus while active clears progress
    a_r5_low_bus_clears: assert property (@(posedge clk) disable iff (rst)
        (st_q.phase != PH_IDLE && !bus_hi) |=> (st_q.cnt == '0 && !may_start));

    // R7: start event restarts from zero
    a_r7_trigger_restarts: assert property (@(posedge clk) disable iff (rst)
        trigger |=> (st_q.phase == PH_COUNT && st_q.cnt == '0));

    // R6: readiness only follows a tick seen with the bus high
    a_r6_rise_on_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(may_start) |-> ($past(tick) && $past(bus_hi)));

    // R6: count only moves in single steps while the bus stays high
    a_r6_single_step: assert property (@(posedge clk) disable iff (rst)
        (st_q.phase == PH_COUNT && !trigger && bus_hi) |=>
        (st_q.cnt == $past(st_q.cnt) || st_q.cnt == CNT_W'($past(st_q.cnt) + 1'b1)));

    // R9: nothing happens before a start event
    a_r9_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (st_q.phase == PH_IDLE && !trigger) |=> !may_start);

    // R8: synchronous reset clears count and readiness
    a_r8_reset_clears: assert property (@(posedge clk)
        rst |=> (!may_start && st_q.cnt == '0));

endmodule

// File: rtl/bus_idle_guard.sv
module bus_idle_guard
    import idle_guard_pkg::*;
#(
    parameter int CODE_W = 3,
    parameter int LOST_H = 5,
    parameter int NEW_H  = 10,
    parameter int OWN_H  = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] idle_code,
    input  logic              start_on_end,
    input  logic              sw_start,
    input  logic              tx_done,
    input  logic              rx_done,
    input  logic              arb_lost,
    input  logic              half_tick,
    input  logic              bus_hi,
    output logic              may_start
);

    localparam int MAX_H = max_half(CODE_W, LOST_H, NEW_H, OWN_H);
    localparam int CNT_W = $clog2(MAX_H + 1);

    hist_e            hist;
    logic [CNT_W-1:0] target;
    logic             trigger;

    // start source selection
    assign trigger = start_on_end ? (tx_done | rx_done) : sw_start;

    ig_history u_hist (
        .clk      (clk),
        .rst      (rst),
        .arb_lost (arb_lost),
        .tx_done  (tx_done),
        .rx_done  (rx_done),
        .hist_o   (hist)
    );

    ig_target #(
        .CODE_W (CODE_W),
        .CNT_W  (CNT_W),
        .LOST_H (LOST_H),
        .NEW_H  (NEW_H),
        .OWN_H  (OWN_H)
    ) u_target (
        .code     (idle_code),
        .hist     (hist),
        .target_o (target)
    );

    ig_window #(
        .CNT_W (CNT_W)
    ) u_win (
        .clk       (clk),
        .rst       (rst),
        .trigger   (trigger),
        .tick      (half_tick),
        .bus_hi    (bus_hi),
        .target    (target),
        .may_start (may_start)
    );

    // R4: in end-of-message mode a lone software request does not drop readiness
    a_r4_sw_ignored: assert property (@(posedge clk) disable iff (rst)
        (start_on_end && sw_start && !tx_done && !rx_done && bus_hi && may_start)
        |=> may_start);

    // R3: in software mode message ends do not drop readiness
    a_r3_end_ignored: assert property (@(posedge clk) disable iff (rst)
        (!start_on_end && !sw_start && (tx_done || rx_done) && bus_hi && may_start)
        |=> may_start);

endmodule

// File: tb/bus_idle_guard_test.sv
module bus_idle_guard_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] idle_code = '0;
    logic       start_on_end = 1'b0;
    logic       sw_start = 1'b0;
    logic       tx_done = 1'b0;
    logic       rx_done = 1'b0;
    logic       arb_lost = 1'b0;
    logic       half_tick = 1'b0;
    logic       bus_hi = 1'b1;
    logic       may_start;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // reference state: hist 0 new / 1 lost / 2 own; phase 0 idle / 1 count / 2 ready
    int m_hist = 0;
    int m_ph = 0;
    int m_cnt = 0;

    bus_idle_guard uut (
        .clk(clk), .rst(rst), .idle_code(idle_code), .start_on_end(start_on_end),
        .sw_start(sw_start), .tx_done(tx_done), .rx_done(rx_done),
        .arb_lost(arb_lost), .half_tick(half_tick), .bus_hi(bus_hi),
        .may_start(may_start)
    );

    always #2 clk = ~clk;

    function automatic int tgt_of(input int code, input int h);
        if (code != 0) return 2 * code - 1;
        if (h == 1) return 5;
        if (h == 2) return 14;
        return 10;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: may_start=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: update the reference with the applied inputs, then compare
    task automatic step(input string tag);
        int tgt;
        bit trig;
        @(posedge clk);
        tgt  = tgt_of(idle_code, m_hist);
        trig = start_on_end ? (tx_done || rx_done) : sw_start;
        if (rst) begin
            m_hist = 0; m_ph = 0; m_cnt = 0;
        end else begin
            if (arb_lost) m_hist = 1;
            else if (tx_done) m_hist = 2;
            else if (rx_done) m_hist = 0;
            if (trig) begin
                m_ph = 1; m_cnt = 0;
            end else if (m_ph != 0 && !bus_hi) begin
                m_ph = 1; m_cnt = 0;
            end else if (m_ph == 1 && half_tick) begin
                m_cnt++;
                if (m_cnt >= tgt) m_ph = 2;
            end
        end
        #1;
        chk(tag, int'(may_start), (m_ph == 2) ? 1 : 0);
        sw_start = 0; tx_done = 0; rx_done = 0; arb_lost = 0; half_tick = 0;
    endtask

    // tick n times with the bus high; ready must appear exactly on tick n
    task automatic count_to(input string tag, input int n);
        for (int i = 1; i <= n; i++) begin
            half_tick = 1;
            step(tag);
            chk(tag, int'(may_start), (i == n) ? 1 : 0);
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #1;
        // R8: reset state
        rst = 1; step("R8"); step("R8");
        chk("R8", int'(may_start), 0);
        rst = 0;

        // R9: ticks before any start event
        for (int i = 0; i < 20; i++) begin half_tick = 1; step("R9"); end
        chk("R9", int'(may_start), 0);

        // R3 + R2: software start, default new-initiator target 10
        start_on_end = 0; idle_code = 0;
        sw_start = 1; step("R3");
        count_to("R2", 10);

        // R1: coded targets, also a tick in the start cycle (R7)
        idle_code = 1; sw_start = 1; half_tick = 1; step("R7");
        chk("R7", int'(may_start), 0);
        count_to("R1", 1);
        idle_code = 4; sw_start = 1; step("R1");
        count_to("R1", 7);
        idle_code = 7; sw_start = 1; step("R1");
        count_to("R1", 13);

        // R3: message ends in software mode start nothing, stay ready
        tx_done = 1; step("R3");
        chk("R3", int'(may_start), 1);
        rx_done = 1; step("R3");
        chk("R3", int'(may_start), 1);

        // R2: after arb loss, default target 5
        idle_code = 0; arb_lost = 1; step("R2");
        sw_start = 1; step("R2");
        count_to("R2", 5);

        // R2 + R4: own transmission end starts a 14-tick wait
        start_on_end = 1; tx_done = 1; step("R4");
        chk("R4", int'(may_start), 0);
        count_to("R2", 14);
        // R4: software request ignored in this mode
        sw_start = 1; step("R4");
        chk("R4", int'(may_start), 1);
        // R2: priority when pulses coincide -> lost wins
        arb_lost = 1; tx_done = 1; rx_done = 1; step("R2");
        count_to("R2", 5);
        // R2: reception end -> new initiator 10
        rx_done = 1; step("R4");
        count_to("R2", 10);

        // R5: bus low mid-count restarts, then full target again
        start_on_end = 0; idle_code = 3; sw_start = 1; step("R5");
        for (int i = 0; i < 3; i++) begin half_tick = 1; step("R5"); end
        bus_hi = 0; half_tick = 1; step("R5");
        bus_hi = 1;
        count_to("R5", 5);
        // R5: bus low while ready drops the flag
        bus_hi = 0; step("R5");
        chk("R5", int'(may_start), 0);
        bus_hi = 1;
        count_to("R6", 5);
        // R6: idle cycles keep the flag
        for (int i = 0; i < 4; i++) step("R6");
        chk("R6", int'(may_start), 1);

        // R7: start event while ready
        sw_start = 1; step("R7");
        chk("R7", int'(may_start), 0);

        // R8: reset mid-count, history back to new-initiator
        idle_code = 0; tx_done = 1; step("R8");
        sw_start = 1; step("R8");
        half_tick = 1; step("R8");
        rst = 1; step("R8");
        chk("R8", int'(may_start), 0);
        rst = 0;
        for (int i = 0; i < 12; i++) begin half_tick = 1; step("R9"); end
        chk("R9", int'(may_start), 0);
        sw_start = 1; step("R8");
        count_to("R8", 10);

        // random phase against the reference model
        void'($urandom(32'h1d1e));
        for (int i = 0; i < 4000; i++) begin
            if (i % 150 == 0) begin
                idle_code = 3'($urandom_range(0, 7));
                start_on_end = 1'($urandom_range(0, 1));
            end
            half_tick = ($urandom_range(0, 2) != 0);
            bus_hi    = ($urandom_range(0, 39) != 0);
            sw_start  = ($urandom_range(0, 29) == 0);
            tx_done   = ($urandom_range(0, 39) == 0);
            rx_done   = ($urandom_range(0, 39) == 0);
            arb_lost  = ($urandom_range(0, 59) == 0);
            step("R6");
        end
        bus_hi = 1;

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule